// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider

This block divides a single fast clock by a programmable integer ratio R = 8·M + A. It does this with a pulse-swallow chain. A prescaler core counts either 9 or 8 input clocks per prescaler cycle. An up-counter tracks how many prescaler cycles have finished in the current output period. While that count is below A, the prescaler uses the longer modulus of 9. After that it uses 8, until M prescaler cycles have completed.

The ratio comes from a 14-bit static word with no load strobe. Bits [2:0] hold A and bits [13:3] hold M. The block reads the word only when a new output period begins, so the word can change at any time.

Each period produces one output pulse. The pulse is high for the first 8 input clocks of the period, which is one short prescaler period. An enable input gates it. A word that gives a ratio below 56 is replaced by 56, and a sticky error flag records the event.

Top module: `dms_divider`

## Requirements
- R1: With an accepted word, the output period is exactly 8·M + A input clock cycles, where A = div_word[2:0] and M = div_word[13:3].
- R2: Every ratio from 56 to 16383 is produced exactly, including the ratios 56 to 63 (M = 7, A = 0..7). In every period the A modulus-9 prescaler cycles come before the modulus-8 ones.
- R3: While out_en is high, div_pulse is high for the first 8 input clock cycles of each period and low for the rest of the period.
- R4: While out_en is low, div_pulse is low. out_en has no effect on the counting, so the period phase continues unchanged while the output is gated.
- R5: The block samples div_word only on the clock edge that starts a new period (and on reset edges). A change in the middle of a period does not alter the length of that period.
- R6: A sampled word with M < 7 (ratio below 56, which also covers M < A) is run as ratio 56 and sets cfg_err. cfg_err stays high until the next reset.
- R7: rst is synchronous and active high. While rst is high, div_pulse is low. The cycle after the last reset edge is cycle 0 of a new period, which uses the word present at that edge. After reset, cfg_err shows whether that word was rejected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous reset, active high |
| div_word | input | 14 | Division word: [2:0] = A, [13:3] = M |
| out_en | input | 1 | Output enable, active high |
| div_pulse | output | 1 | Divided output pulse, 8 clocks wide per period |
| cfg_err | output | 1 | Sticky flag: a rejected word was sampled |

## Verification
The bench uses the default parameters: modulus 8, a 3-bit A field and an 11-bit M field. With these, the whole legal ratio range fits into the cycle budget. That covers the smallest ratio 56, the fully swallowed case M = 7 with A = 7, and the largest ratio 16383, which runs as a full 16383-cycle period more than once. A behavioural model predicts the pulse and the error flag on every clock. The bench also checks word changes in the middle of a period, gating by the enable, rejected words, and resets taken with both good and bad words.

// File: rtl/dms_pkg.sv
package dms_pkg;
   typedef enum logic {
      MOD_SHORT = 1'b0,
      MOD_LONG  = 1'b1
   } modsel_e;
endpackage

// File: rtl/dms_word_sampler.sv
module dms_word_sampler #(
   parameter int A_W   = 3,
   parameter int M_W   = 11,
   parameter int MIN_M = 7
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           load,
   input  logic [A_W+M_W-1:0] word,
   output logic [A_W-1:0] lat_a,
   output logic [M_W-1:0] lat_m,
   output logic           err
);
   logic [A_W-1:0] w_a;
   logic [M_W-1:0] w_m;
   logic           w_bad;

   assign w_a   = word[A_W-1:0];
   assign w_m   = word[A_W+M_W-1:A_W];
   assign w_bad = (w_m < M_W'(MIN_M)) || (w_m < M_W'(w_a));

   always_ff @(posedge clk) begin
      if (rst || load) begin
         lat_a <= w_bad ? '0 : w_a;
         lat_m <= w_bad ? M_W'(MIN_M) : w_m;
      end
      if (rst)       err <= w_bad;
      else if (load) err <= err | w_bad;
   end
endmodule

// File: rtl/dms_prescaler.sv
module dms_prescaler
   import dms_pkg::*;
#(
   parameter int PRE_N = 8,
   parameter int PC_W  = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  modsel_e         modsel,
   output logic [PC_W-1:0] pc,
   output logic            tick
);
   localparam logic [PC_W-1:0] LAST_SHORT = PC_W'(PRE_N - 1);
   localparam logic [PC_W-1:0] LAST_LONG  = PC_W'(PRE_N);

   assign tick = (pc == ((modsel == MOD_LONG) ? LAST_LONG : LAST_SHORT));

   always_ff @(posedge clk) begin
      if (rst || tick) pc <= '0;
      else             pc <= pc + 1'b1;
   end
endmodule

// File: rtl/dms_swallow_ctr.sv
module dms_swallow_ctr
   import dms_pkg::*;
#(
   parameter int A_W = 3,
   parameter int M_W = 11
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           tick,
   input  logic [A_W-1:0] lat_a,
   input  logic [M_W-1:0] lat_m,
   output logic [M_W-1:0] mcnt,
   output modsel_e        modsel,
   output logic           period_end
);
   localparam int PAD = M_W - A_W;

   logic [M_W-1:0] a_ext;
   assign a_ext = {{PAD{1'b0}}, lat_a};

   assign modsel     = (mcnt < a_ext) ? MOD_LONG : MOD_SHORT;
   assign period_end = tick && (mcnt == (lat_m - M_W'(1)));

   always_ff @(posedge clk) begin
      if (rst || period_end) mcnt <= '0;
      else if (tick)         mcnt <= mcnt + 1'b1;
   end
endmodule

// File: rtl/dms_divider.sv
module dms_divider
   import dms_pkg::*;
#(
   parameter int PRE_N = 8,
   parameter int M_W   = 11
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [$clog2(PRE_N)+M_W-1:0] div_word,
   input  logic                        out_en,
   output logic                        div_pulse,
   output logic                        cfg_err
);
   localparam int A_W    = $clog2(PRE_N);
   localparam int WORD_W = A_W + M_W;
   localparam int PC_W   = $clog2(PRE_N + 1);
   localparam int MIN_M  = PRE_N - 1;

   generate
      if ((1 << A_W) != PRE_N) begin : g_bad_modulus
         $error("PRE_N must be a power of two");
      end
      if (PRE_N < 4) begin : g_small_modulus
         $error("PRE_N must be at least 4");
      end
      if (M_W <= A_W) begin : g_narrow_m
         $error("M field must be wider than the A field");
      end
      if (WORD_W > 30) begin : g_wide_word
         $error("division word too wide");
      end
   endgenerate

   logic [A_W-1:0]  lat_a;
   logic [M_W-1:0]  lat_m;
   logic [M_W-1:0]  mcnt_q;
   logic [PC_W-1:0] pc_q;
   logic            tick;
   logic            period_end;
   modsel_e         modsel;

   dms_word_sampler #(
      .A_W  (A_W),
      .M_W  (M_W),
      .MIN_M(MIN_M)
   ) u_sampler (
      .clk  (clk),
      .rst  (rst),
      .load (period_end),
      .word (div_word),
      .lat_a(lat_a),
      .lat_m(lat_m),
      .err  (cfg_err)
   );

   dms_prescaler #(
      .PRE_N(PRE_N),
      .PC_W (PC_W)
   ) u_prescaler (
      .clk   (clk),
      .rst   (rst),
      .modsel(modsel),
      .pc    (pc_q),
      .tick  (tick)
   );

   dms_swallow_ctr #(
      .A_W(A_W),
      .M_W(M_W)
   ) u_swallow (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .lat_a     (lat_a),
      .lat_m     (lat_m),
      .mcnt      (mcnt_q),
      .modsel    (modsel),
      .period_end(period_end)
   );

   assign div_pulse = out_en && !rst && (mcnt_q == '0) && (pc_q < PC_W'(PRE_N));
endmodule

// File: rtl/dms_divider_chk.sv
module dms_divider_chk
   import dms_pkg::*;
#(
   parameter int PRE_N = 8,
   parameter int A_W   = 3,
   parameter int M_W   = 11,
   parameter int PC_W  = 4
) (
   input logic            clk,
   input logic            rst,
   input logic            out_en,
   input logic            div_pulse,
   input logic            cfg_err,
   input logic [PC_W-1:0] pc_q,
   input logic [M_W-1:0]  mcnt_q,
   input logic [A_W-1:0]  lat_a,
   input logic [M_W-1:0]  lat_m,
   input modsel_e         modsel,
   input logic            period_end
);
   // R1: prescaler count never passes the long modulus
   a_r1_pc_range: assert property (@(posedge clk) disable iff (rst)
      pc_q <= PC_W'(PRE_N));

   // R1: prescaler-cycle count stays below the latched M
   a_r1_mcnt_range: assert property (@(posedge clk) disable iff (rst)
      mcnt_q < lat_m);

   // R2: long modulus only in the first A prescaler cycles
   a_r2_swallow_first: assert property (@(posedge clk) disable iff (rst)
      (modsel == MOD_LONG) |-> (mcnt_q < M_W'(lat_a)));

   // R3: an enabled pulse ends only when the first short window is over
   a_r3_pulse_end: assert property (@(posedge clk) disable iff (rst)
      ($fell(div_pulse) && out_en && $past(out_en)) |-> (mcnt_q != '0 || pc_q == PC_W'(PRE_N)));

   // R4: gated output stays low
   a_r4_gate: assert property (@(posedge clk) disable iff (rst)
      !out_en |-> !div_pulse);

   // R5: latched word holds between period boundaries
   a_r5_word_hold: assert property (@(posedge clk) disable iff (rst)
      !period_end |=> ($stable(lat_m) && $stable(lat_a)));

   // R6: error flag is sticky
   a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
      cfg_err |=> cfg_err);

   // R6: latched word is always legal
   a_r6_legal_latch: assert property (@(posedge clk) disable iff (rst)
      lat_m >= M_W'(PRE_N - 1));

   // R7: no pulse while reset is applied
   always @(negedge clk) begin
      if (rst === 1'b1) begin
         a_r7_reset_quiet: assert (!div_pulse);
      end
   end
endmodule

bind dms_divider dms_divider_chk #(
   .PRE_N(PRE_N),
   .A_W  (A_W),
   .M_W  (M_W),
   .PC_W (PC_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .out_en    (out_en),
   .div_pulse (div_pulse),
   .cfg_err   (cfg_err),
   .pc_q      (pc_q),
   .mcnt_q    (mcnt_q),
   .lat_a     (lat_a),
   .lat_m     (lat_m),
   .modsel    (modsel),
   .period_end(period_end)
);

// File: tb/dms_divider_bench.sv
`timescale 1ns/1ps
module dms_divider_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [13:0] div_word = 14'd56;
   logic        out_en = 1'b1;
   logic        div_pulse;
   logic        cfg_err;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   // behavioural reference state
   int  m_m = 7, m_a = 0, m_len = 56, m_t = 0;
   bit  m_err = 0;
   bit  m_live = 0;

   always #2.5 clk = ~clk;

   dms_divider u_dms_divider (
      .clk      (clk),
      .rst      (rst),
      .div_word (div_word),
      .out_en   (out_en),
      .div_pulse(div_pulse),
      .cfg_err  (cfg_err)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cycles, act, exp);
      end
   endtask

   function automatic bit word_bad(input logic [13:0] w);
      return (int'(w[13:3]) < 7) || (int'(w[13:3]) < int'(w[2:0]));
   endfunction

   task automatic take_word(input logic [13:0] w);
      if (word_bad(w)) begin
         m_m = 7; m_a = 0;
      end else begin
         m_m = int'(w[13:3]); m_a = int'(w[2:0]);
      end
      m_len = m_m * 8 + m_a;
   endtask

   // model advance on each edge (R1 R5 R6 R7)
   always @(posedge clk) begin
      cycles++;
      if (rst) begin
         take_word(div_word);
         m_t = 0;
         m_err = word_bad(div_word);
         m_live = 1;
      end else if (m_t == m_len - 1) begin
         if (word_bad(div_word)) m_err = 1;
         take_word(div_word);
         m_t = 0;
      end else begin
         m_t++;
      end
      if (cycles >= 190000) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (m_live) begin
         bit    exp_p;
         string tag;
         exp_p = !rst && out_en && (m_t < 8);
         if (rst)          tag = "R7 pulse held low in reset";
         else if (!out_en) tag = "R4 gated pulse";
         else if (m_t < 8) tag = "R3 pulse window";
         else              tag = "R1 period timing";
         chk(div_pulse === exp_p, tag, int'(div_pulse), int'(exp_p));
         chk(cfg_err === m_err, rst ? "R7 error after reset" : "R6 error flag",
             int'(cfg_err), int'(m_err));
      end
   end

   task automatic run(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   function automatic logic [13:0] mk(input int m, input int a);
      return {11'(m), 3'(a)};
   endfunction

   initial begin
      // R7: reset with the minimum ratio word
      run(3);
      rst = 1'b0;
      run(3 * 56);
      // R2: ratios 56..63 with every swallow count
      for (int a = 1; a < 8; a++) begin
         div_word = mk(7, a);
         run(3 * (56 + a));
      end
      // R1: assorted ratios
      div_word = mk(8, 0);   run(3 * 64);
      div_word = mk(12, 4);  run(3 * 100);
      div_word = mk(9, 3);   run(3 * 75);
      // R5: change word mid-period, then again before the boundary
      run(20);
      div_word = mk(20, 5);
      run(10);
      div_word = mk(10, 1);
      run(4 * 165);
      // R4: gate output for part of periods, phase must continue
      out_en = 1'b0; run(130);
      out_en = 1'b1; run(50);
      out_en = 1'b0; run(3);
      out_en = 1'b1; run(3 * 81);
      // R6: rejected word (M=3, A=5) runs at 56 and sets the sticky flag
      div_word = mk(3, 5);  run(3 * 81 + 3 * 56);
      div_word = mk(7, 7);  run(3 * 63);
      // R7: reset with a bad word leaves the flag set; with a good word clears it
      rst = 1'b1; div_word = mk(2, 0); run(2);
      rst = 1'b0; run(2 * 56);
      rst = 1'b1; div_word = mk(15, 2); run(2);
      rst = 1'b0; run(3 * 122);
      // R2: largest ratio 16383
      div_word = 14'h3FFF; run(122 + 2 * 16383 + 20);
      // R7: reset in the middle of a long period
      rst = 1'b1; div_word = mk(7, 3); run(1);
      rst = 1'b0; run(3 * 59);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule